// File: doc/BRIEF.md
# Link Rate Change Sequencer

This block walks a multi-lane serial PHY through a change of line rate. It is started by a one-cycle request that carries a lane count and a 3-bit rate index. It then drives a simple single-transfer register bus and a power-state handshake in a fixed order. First the active lanes are put into the deepest power state and their PLL clocks are gated. Next the common PLL is turned off and confirmed off, and a short rate-specific list of register writes is issued. The PLL is then turned back on and confirmed ready. Last, the lane clocks are re-enabled and the power state is raised through an intermediate level to the active one. Each confirmation is a repeated status read. Fixed settling delays, given in nanoseconds and converted to clock cycles, separate the steps.

Every step that waits for the outside world is limited by a cycle timeout. When the limit is reached, the sequence stops where it is, issues no further transfers and reports completion with an error.

States, in order: `ST_IDLE` → `ST_PWR_DEEP` → `ST_CLK_OFF_WR` → `ST_CLK_OFF_POLL` → `ST_CLK_OFF_SETTLE` → `ST_GAP_PRE` → `ST_PLL_OFF_WR` → `ST_PLL_OFF_POLL` → `ST_PLL_OFF_SETTLE` → `ST_CFG_WR` (one pass per table entry) → `ST_PLL_ON_WR` → `ST_PLL_ON_POLL` → `ST_GAP_POST` → `ST_CLK_ON_WR` → `ST_CLK_ON_POLL` → `ST_CLK_ON_SETTLE` → `ST_PWR_MID` → `ST_PWR_ACT` → `ST_FINAL_WAIT` → `ST_REPORT` → `ST_IDLE`. A poll state stays in place while the read result does not match. A timeout in any handshake state goes straight to `ST_REPORT` with the error flag set.

Top module: `link_rate_seq`

## Requirements
- R1: Out of reset and whenever not busy, `busy`, `done`, `error`, `bus_req` and `pwr_req` are all low.
- R2: The lane clock mask is 0x1 for a lane count of 1, 0x3 for 2, and 0xF for any other count. Gating writes 0 to the lane clock-enable register (address 0x24). Enabling writes the mask to that register.
- R3: The transfers of a run come in exactly this order: power request deep, clock-enable write of 0, acknowledge polls, PLL control write of 0 (0x3800C), PLL status polls (0x38004), table writes, PLL control write of 0x3, PLL status polls, clock-enable write of the mask, acknowledge polls, power request mid, power request active. Bus signals hold steady while a transfer waits for `bus_ack`.
- R4: A lane clock poll reads address 0x28 again and again until (read data AND mask) equals the value just written to 0x24.
- R5: The PLL-off poll repeats until status bit 2 reads 1. The PLL-on poll repeats until status bit 0 reads 1.
- R6: The rate table issues NUM_CFG writes. Entry k goes to CFG_BASE + 4·k with data rate_sel·256 + k, using the rate index latched at start.
- R7: Each settle delay lasts ceil(ns·1000 / CLK_PERIOD_PS) cycles: 100 ns after each clock poll, 200 ns before and after the PLL reprogramming and after the PLL-off poll, and 900 ns after the final power step. With 125 MHz these are 13, 25 and 113 cycles.
- R8: `pwr_state` encodes active = 2'b00, mid = 2'b10, deep = 2'b11, and is held with `pwr_req` until `pwr_ack`.
- R9: If a handshake state sees no success within TIMEOUT_CYC cycles, `done` and `error` rise together one cycle later, and no further bus or power transfer follows.
- R10: A `start` pulse while busy is ignored. The running sequence keeps its latched lane count and rate.
- R11: `done` is a one-cycle pulse at the end of every run. `error` is high only together with `done`, and it is low for a successful run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a rate change (sampled when idle) |
| lane_cnt | input | 3 | Number of active lanes |
| rate_sel | input | 3 | Rate index choosing the table data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Completion was caused by a timeout |
| bus_req | output | 1 | Register transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Transfer completes on a clock with req and ack high |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| pwr_req | output | 1 | Power-state change request |
| pwr_state | output | 2 | Requested power state |
| pwr_ack | input | 1 | Power-state change accepted |

## Verification
The bench models acknowledge and PLL status registers that return a stale value for a chosen number of reads. A design that stops polling after the first read, or that tests the wrong status bit, then makes a different number of transfers from the one the scoreboard expects. Settle lengths are measured as exact cycle distances between completed transfers and between the last power step and `done`. An off-by-one in the rounding or the counter end shows up as a gap error. A start pulse with different settings is injected mid-run, so a design that re-latches would write wrong table data. A frozen status register forces a timeout, and the bench then requires `done`+`error` at the exact cycle, followed by a silent bus. A design that carried on after the error would be caught by that quiet-bus check.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PWR_DEEP,
        ST_CLK_OFF_WR,
        ST_CLK_OFF_POLL,
        ST_CLK_OFF_SETTLE,
        ST_GAP_PRE,
        ST_PLL_OFF_WR,
        ST_PLL_OFF_POLL,
        ST_PLL_OFF_SETTLE,
        ST_CFG_WR,
        ST_PLL_ON_WR,
        ST_PLL_ON_POLL,
        ST_GAP_POST,
        ST_CLK_ON_WR,
        ST_CLK_ON_POLL,
        ST_CLK_ON_SETTLE,
        ST_PWR_MID,
        ST_PWR_ACT,
        ST_FINAL_WAIT,
        ST_REPORT
    } seq_state_t;

    localparam logic [1:0] PWR_ACTIVE = 2'b00;
    localparam logic [1:0] PWR_MID    = 2'b10;
    localparam logic [1:0] PWR_DEEP   = 2'b11;

    // Delay in ns turned into whole clock cycles, rounded up.
    function automatic int ns_to_cycles(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/lrs_step_timer.sv
module lrs_step_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Cycle counter for the current step; saturates instead of wrapping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lrs_lane_mask.sv
module lrs_lane_mask #(
    parameter int NUM_LANES = 4
) (
    input  logic [2:0]           lane_cnt,
    output logic [NUM_LANES-1:0] mask
);
    always_comb begin
        unique case (lane_cnt)
            3'd1:    mask = NUM_LANES'(1);
            3'd2:    mask = NUM_LANES'(3);
            default: mask = {NUM_LANES{1'b1}};
        endcase
    end
endmodule

// File: rtl/lrs_rate_cfg.sv
module lrs_rate_cfg #(
    parameter int              ADDR_W   = 20,
    parameter int              DATA_W   = 32,
    parameter int              IDX_W    = 2,
    parameter logic [ADDR_W-1:0] CFG_BASE = '0
) (
    input  logic [2:0]        rate,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    // Entry k of the list: word-spaced address, data carries rate and k.
    always_comb begin
        addr = CFG_BASE + (ADDR_W'(idx) << 2);
        data = DATA_W'({rate, 8'(idx)});
    end
endmodule

// File: rtl/link_rate_seq.sv
module link_rate_seq
    import lrs_pkg::*;
#(
    parameter int              ADDR_W        = 20,
    parameter int              DATA_W        = 32,
    parameter int              NUM_LANES     = 4,
    parameter int              CLK_PERIOD_PS = 8000,
    parameter int              TIMEOUT_CYC   = 4096,
    parameter int              NUM_CFG       = 4,
    parameter logic [ADDR_W-1:0] CLK_EN_ADDR   = ADDR_W'(32'h00024),
    parameter logic [ADDR_W-1:0] CLK_ACK_ADDR  = ADDR_W'(32'h00028),
    parameter logic [ADDR_W-1:0] PLL_CTL_ADDR  = ADDR_W'(32'h3800C),
    parameter logic [ADDR_W-1:0] PLL_STAT_ADDR = ADDR_W'(32'h38004),
    parameter logic [ADDR_W-1:0] CFG_BASE      = ADDR_W'(32'h00400)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        lane_cnt,
    input  logic [2:0]        rate_sel,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              pwr_req,
    output logic [1:0]        pwr_state,
    input  logic              pwr_ack
);
    localparam int CYC_SHORT = ns_to_cycles(100, CLK_PERIOD_PS);
    localparam int CYC_MID   = ns_to_cycles(200, CLK_PERIOD_PS);
    localparam int CYC_LONG  = ns_to_cycles(900, CLK_PERIOD_PS);
    localparam int TMR_W     = $clog2(TIMEOUT_CYC + CYC_LONG + 2);
    localparam int CFG_IW    = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
    localparam logic [DATA_W-1:0] PLL_OFF_BIT = DATA_W'(4);
    localparam logic [DATA_W-1:0] PLL_RDY_BIT = DATA_W'(1);
    localparam logic [DATA_W-1:0] PLL_ON_VAL  = DATA_W'(3);

    seq_state_t           state_q, state_d;
    logic [2:0]           lanes_q;
    logic [2:0]           rate_q;
    logic [CFG_IW-1:0]    idx_q;
    logic                 err_q;
    logic [TMR_W-1:0]     tmr;
    logic                 tmr_clr;
    logic [NUM_LANES-1:0] mask;
    logic [DATA_W-1:0]    mask_w;
    logic [ADDR_W-1:0]    cfg_addr;
    logic [DATA_W-1:0]    cfg_data;
    logic                 handshake;
    logic                 timed_out;
    logic                 xfer;

    lrs_step_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr)
    );

    lrs_lane_mask #(.NUM_LANES(NUM_LANES)) u_mask (
        .lane_cnt (lanes_q),
        .mask     (mask)
    );

    lrs_rate_cfg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IDX_W    (CFG_IW),
        .CFG_BASE (CFG_BASE)
    ) u_cfg (
        .rate (rate_q),
        .idx  (idx_q),
        .addr (cfg_addr),
        .data (cfg_data)
    );

    assign mask_w = DATA_W'(mask);
    assign xfer   = bus_req && bus_ack;

    // States that wait on the bus or the power handshake are timeout-limited.
    always_comb begin
        unique case (state_q)
            ST_PWR_DEEP, ST_CLK_OFF_WR, ST_CLK_OFF_POLL, ST_PLL_OFF_WR,
            ST_PLL_OFF_POLL, ST_CFG_WR, ST_PLL_ON_WR, ST_PLL_ON_POLL,
            ST_CLK_ON_WR, ST_CLK_ON_POLL, ST_PWR_MID, ST_PWR_ACT:
                handshake = 1'b1;
            default:
                handshake = 1'b0;
        endcase
    end

    assign timed_out = handshake && (tmr == TMR_W'(TIMEOUT_CYC - 1));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (timed_out) begin
            state_d = ST_REPORT;
        end else begin
            unique case (state_q)
                ST_IDLE:           if (start) state_d = ST_PWR_DEEP;
                ST_PWR_DEEP:       if (pwr_ack) state_d = ST_CLK_OFF_WR;
                ST_CLK_OFF_WR:     if (xfer) state_d = ST_CLK_OFF_POLL;
                ST_CLK_OFF_POLL:   if (xfer && ((bus_rdata & mask_w) == '0))
                                       state_d = ST_CLK_OFF_SETTLE;
                ST_CLK_OFF_SETTLE: if (tmr == TMR_W'(CYC_SHORT - 1)) state_d = ST_GAP_PRE;
                ST_GAP_PRE:        if (tmr == TMR_W'(CYC_MID - 1)) state_d = ST_PLL_OFF_WR;
                ST_PLL_OFF_WR:     if (xfer) state_d = ST_PLL_OFF_POLL;
                ST_PLL_OFF_POLL:   if (xfer && ((bus_rdata & PLL_OFF_BIT) != '0))
                                       state_d = ST_PLL_OFF_SETTLE;
                ST_PLL_OFF_SETTLE: if (tmr == TMR_W'(CYC_MID - 1)) state_d = ST_CFG_WR;
                ST_CFG_WR:         if (xfer && (idx_q == CFG_IW'(NUM_CFG - 1)))
                                       state_d = ST_PLL_ON_WR;
                ST_PLL_ON_WR:      if (xfer) state_d = ST_PLL_ON_POLL;
                ST_PLL_ON_POLL:    if (xfer && ((bus_rdata & PLL_RDY_BIT) != '0))
                                       state_d = ST_GAP_POST;
                ST_GAP_POST:       if (tmr == TMR_W'(CYC_MID - 1)) state_d = ST_CLK_ON_WR;
                ST_CLK_ON_WR:      if (xfer) state_d = ST_CLK_ON_POLL;
                ST_CLK_ON_POLL:    if (xfer && ((bus_rdata & mask_w) == mask_w))
                                       state_d = ST_CLK_ON_SETTLE;
                ST_CLK_ON_SETTLE:  if (tmr == TMR_W'(CYC_SHORT - 1)) state_d = ST_PWR_MID;
                ST_PWR_MID:        if (pwr_ack) state_d = ST_PWR_ACT;
                ST_PWR_ACT:        if (pwr_ack) state_d = ST_FINAL_WAIT;
                ST_FINAL_WAIT:     if (tmr == TMR_W'(CYC_LONG - 1)) state_d = ST_REPORT;
                ST_REPORT:         state_d = ST_IDLE;
                default:           state_d = ST_IDLE;
            endcase
        end
    end

    // Timer restarts on every state change and on each table write.
    assign tmr_clr = (state_d != state_q) || ((state_q == ST_CFG_WR) && xfer);

    // State register and the values latched with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lanes_q <= 3'd0;
            rate_q  <= 3'd0;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                lanes_q <= lane_cnt;
                rate_q  <= rate_sel;
                idx_q   <= '0;
                err_q   <= 1'b0;
            end else if (timed_out) begin
                err_q <= 1'b1;
            end else if (state_q == ST_CFG_WR && xfer) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        pwr_req   = 1'b0;
        pwr_state = PWR_ACTIVE;
        done      = 1'b0;
        error     = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_PWR_DEEP:     begin pwr_req = 1'b1; pwr_state = PWR_DEEP; end
            ST_PWR_MID:      begin pwr_req = 1'b1; pwr_state = PWR_MID; end
            ST_PWR_ACT:      begin pwr_req = 1'b1; pwr_state = PWR_ACTIVE; end
            ST_CLK_OFF_WR:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = CLK_EN_ADDR; end
            ST_CLK_ON_WR:    begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = CLK_EN_ADDR; bus_wdata = mask_w;
            end
            ST_CLK_OFF_POLL,
            ST_CLK_ON_POLL:  begin bus_req = 1'b1; bus_addr = CLK_ACK_ADDR; end
            ST_PLL_OFF_WR:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = PLL_CTL_ADDR; end
            ST_PLL_ON_WR:    begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = PLL_CTL_ADDR; bus_wdata = PLL_ON_VAL;
            end
            ST_PLL_OFF_POLL,
            ST_PLL_ON_POLL:  begin bus_req = 1'b1; bus_addr = PLL_STAT_ADDR; end
            ST_CFG_WR:       begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = cfg_addr; bus_wdata = cfg_data;
            end
            ST_REPORT:       begin done = 1'b1; error = err_q; end
            default:         ;
        endcase
    end

    // Checks kept beside the logic they guard.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !pwr_req && !done && !error));

    p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !timed_out) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_pwr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req && !pwr_ack && !timed_out) |=> (pwr_req && $stable(pwr_state)));

    p_timer_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        handshake |-> (tmr < TMR_W'(TIMEOUT_CYC)));

    p_quiet_after_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |=> (done && error && !bus_req && !pwr_req));

    p_hold_settings_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(rate_q) && $stable(lanes_q)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_error_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

endmodule

// File: tb/link_rate_seq_bench.sv
`timescale 1ns/1ps
module link_rate_seq_bench;
    localparam int ADDR_W   = 20;
    localparam int DATA_W   = 32;
    localparam int TIMEOUT  = 64;
    localparam int NCFG     = 4;
    localparam logic [ADDR_W-1:0] A_CLK_EN  = 20'h00024;
    localparam logic [ADDR_W-1:0] A_CLK_ACK = 20'h00028;
    localparam logic [ADDR_W-1:0] A_PLL_CTL = 20'h3800C;
    localparam logic [ADDR_W-1:0] A_PLL_ST  = 20'h38004;
    localparam logic [ADDR_W-1:0] A_CFG     = 20'h00400;

    typedef struct {
        bit                pwr;
        bit                we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        int                gap;
        string             tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] lane_cnt = 3'd0;
    logic [2:0] rate_sel = 3'd0;
    logic busy, done, error, bus_req, bus_we, pwr_req;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic bus_ack = 1'b0;
    logic pwr_ack = 1'b0;
    logic [1:0] pwr_state;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_cyc = 0;
    int plloff_cyc = 0;
    item_t exp_q[$];
    bit drain = 0;
    bit done_seen = 0;
    bit done_err = 0;
    int done_cyc = 0;

    // Register models
    int k_stale = 0;
    bit freeze = 0;
    logic [DATA_W-1:0] clk_ack_v, clk_new_v, pll_cur, pll_new;
    int clk_left, pll_left;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    link_rate_seq #(.TIMEOUT_CYC(TIMEOUT), .NUM_CFG(NCFG)) u_link_rate_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt), .rate_sel(rate_sel),
        .busy(busy), .done(done), .error(error),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .pwr_req(pwr_req), .pwr_state(pwr_state), .pwr_ack(pwr_ack)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic model_reset();
        clk_ack_v = 32'hF; clk_new_v = 32'hF; clk_left = 0;
        pll_cur = 32'h1; pll_new = 32'h1; pll_left = 0;
    endtask

    // Monitor: records each transfer as it is acknowledged and compares it.
    task automatic complete(input bit pwr, input bit we, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d);
        item_t e;
        if (exp_q.size() == 0) begin
            if (drain && !pwr && !we && a == A_PLL_ST) begin
                last_cyc = cyc;
                return;
            end
            check(0, "R3", "unexpected transfer addr", a, 0);
            return;
        end
        e = exp_q.pop_front();
        check(e.pwr == pwr && e.we == we && e.addr == a, e.tag, "transfer kind/addr",
              {pwr, we, a}, {e.pwr, e.we, e.addr});
        if (e.we || e.pwr) check(d == e.data, e.tag, "data", d, e.data);
        if (e.gap >= 0) check(cyc - last_cyc == e.gap, "R7", "cycle gap", cyc - last_cyc, e.gap);
        if (!pwr && we && a == A_PLL_CTL && d == 0) plloff_cyc = cyc;
        last_cyc = cyc;
    endtask

    always @(negedge clk) begin
        if (bus_ack) bus_ack = 1'b0;
        else if (bus_req) begin
            if (bus_addr == A_CLK_ACK) bus_rdata = (clk_left > 0) ? clk_ack_v : clk_new_v;
            else if (bus_addr == A_PLL_ST) bus_rdata = (freeze || pll_left > 0) ? pll_cur : pll_new;
            else bus_rdata = '0;
            complete(1'b0, bus_we, bus_addr, bus_we ? bus_wdata : bus_rdata);
            if (bus_we && bus_addr == A_CLK_EN) begin clk_new_v = bus_wdata; clk_left = k_stale; end
            else if (bus_we && bus_addr == A_PLL_CTL) begin
                pll_new = (bus_wdata == 0) ? 32'h4 : 32'h1; pll_left = k_stale;
            end else if (!bus_we && bus_addr == A_CLK_ACK) begin
                if (clk_left > 0) clk_left--; else clk_ack_v = clk_new_v;
            end else if (!bus_we && bus_addr == A_PLL_ST && !freeze) begin
                if (pll_left > 0) pll_left--; else pll_cur = pll_new;
            end
            bus_ack = 1'b1;
        end
        if (pwr_ack) pwr_ack = 1'b0;
        else if (pwr_req) begin
            complete(1'b1, 1'b0, '0, 32'(pwr_state));
            pwr_ack = 1'b1;
        end
        if (done) begin done_seen = 1; done_err = error; done_cyc = cyc; end
    end

    task automatic push(input bit pwr, input bit we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input int gap, input string tag);
        item_t e;
        e.pwr = pwr; e.we = we; e.addr = a; e.data = d; e.gap = gap; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_reads(input logic [ADDR_W-1:0] a, input int n, input string tag);
        for (int i = 0; i < n; i++) push(0, 0, a, '0, -1, tag);
    endtask

    function automatic logic [31:0] exp_mask(input int lanes);
        return (lanes == 1) ? 32'h1 : (lanes == 2) ? 32'h3 : 32'hF;
    endfunction

    // Driver: pushes the whole expected transfer list of one run.
    task automatic push_run(input int lanes, input int rate, input int k);
        push(1, 0, '0, 32'h3, -1, "R8");                // deep state 2'b11
        push(0, 1, A_CLK_EN, '0, -1, "R2");            // gate: write 0
        push_reads(A_CLK_ACK, k + 1, "R4");
        push(0, 1, A_PLL_CTL, '0, 39, "R3");           // 13 + 25 + 1
        push_reads(A_PLL_ST, k + 1, "R5");
        for (int i = 0; i < NCFG; i++)
            push(0, 1, A_CFG + ADDR_W'(4 * i), 32'(rate * 256 + i), (i == 0) ? 26 : 2, "R6");
        push(0, 1, A_PLL_CTL, 32'h3, -1, "R3");
        push_reads(A_PLL_ST, k + 1, "R5");
        push(0, 1, A_CLK_EN, exp_mask(lanes), 26, "R2");
        push_reads(A_CLK_ACK, k + 1, "R4");
        push(1, 0, '0, 32'h2, 14, "R8");               // mid state 2'b10
        push(1, 0, '0, 32'h0, -1, "R8");               // active 2'b00
    endtask

    task automatic wait_done(input int limit);
        int n = 0;
        while (!done_seen && n < limit) begin @(negedge clk); #1; n++; end
    endtask

    task automatic do_run(input int lanes, input int rate, input int k, input bit poke);
        model_reset();
        k_stale = k;
        done_seen = 0;
        push_run(lanes, rate, k);
        @(negedge clk);
        lane_cnt = 3'(lanes); rate_sel = 3'(rate); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: a second start with other settings while busy
            repeat (60) @(negedge clk);
            lane_cnt = 3'd4; rate_sel = 3'd6; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lane_cnt = 3'(lanes); rate_sel = 3'(rate);
        end
        wait_done(3000);
        check(done_seen, "R11", "done seen", done_seen, 1);
        check(!done_err, "R11", "error on good run", done_err, 0);
        check(done_cyc - last_cyc == 114, "R7", "final wait to done", done_cyc - last_cyc, 114);
        check(exp_q.size() == 0, "R3", "items left", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk); #1;
        check(!done && !busy && !error, "R11", "done is one cycle", {done, busy, error}, 0);
        check(!bus_req && !pwr_req, "R1", "quiet when idle", {bus_req, pwr_req}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !error && !bus_req && !pwr_req, "R1", "reset outputs",
              {busy, done, error, bus_req, pwr_req}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!busy && !bus_req && !pwr_req, "R1", "idle after reset", {busy, bus_req, pwr_req}, 0);

        do_run(4, 5, 2, 0);
        do_run(1, 2, 0, 1);   // R10 check inside
        do_run(2, 7, 3, 0);
        do_run(3, 0, 1, 0);   // R2: other count gives 0xF
        do_run(0, 3, 1, 0);

        // R9: PLL never reports off
        model_reset();
        k_stale = 1; freeze = 1; done_seen = 0;
        push(1, 0, '0, 32'h3, -1, "R8");
        push(0, 1, A_CLK_EN, '0, -1, "R2");
        push_reads(A_CLK_ACK, 2, "R4");
        push(0, 1, A_PLL_CTL, '0, 39, "R3");
        drain = 1;
        @(negedge clk);
        lane_cnt = 3'd4; rate_sel = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(2000);
        check(done_seen && done_err, "R9", "done+error on timeout", {done_seen, done_err}, 3);
        check(done_cyc - plloff_cyc == TIMEOUT + 1, "R9", "timeout cycle",
              done_cyc - plloff_cyc, TIMEOUT + 1);
        check(exp_q.size() == 0, "R9", "items left", exp_q.size(), 0);
        begin
            bit quiet = 1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk); #1;
                if (bus_req || pwr_req || busy || done) quiet = 0;
            end
            check(quiet, "R9", "no transfer after timeout", !quiet, 0);
        end
        drain = 0; freeze = 0;

        do_run(2, 4, 1, 0);   // recovers after an error run

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule